// File: doc/BRIEF.md
# Five-Channel Down-Counting Timer Core

This block holds five independent down-counting timers behind a simple register bus. Each channel keeps a reload value and (for channels 0 to 3) a compare value in buffer registers. A working counter and compare register are loaded from those buffers on request or on automatic reload. Software reads the live count through a read-only observation register. Because the counters run downward, software inverts the value it reads to get a rising timestamp. Each channel advances only on cycles where its own tick enable, supplied by an external prescaler, is high.

All channels share one control word. In that word each channel has a start bit, a manual-load bit, an output-invert bit and an auto-reload bit. The word's bit layout is irregular: a four-bit hole follows channel 0, and the last channel has its reload flag one position lower and has no invert bit. A single interrupt register combines per-channel enables with per-channel pending flags. The pending flags are cleared by writing ones. Each channel drives one interrupt line and one compare flag.

Top module: `multi_timer_core`

## Requirements
- R1: After synchronous reset every register, counter, interrupt line and compare flag is zero.
- R2: The control word is at address 0x08. Channel 0 uses bits 3:0, and channel n (n = 1 to 4) uses the nibble starting at bit 4*(n+1). Within a nibble the order is start (+0), manual load (+1), invert (+2) and auto-reload (+3). Channel 4 takes auto-reload at +2 (bit 22) and has no invert bit. Unused bits read 0, so writing all ones reads back 0x007FFF0F.
- R3: The reload buffer of channel n is at 0x0C+12n. The compare buffer of channel n (n = 0 to 3) is at 0x10+12n. The observation register is at 0x14+12n for channels 0 to 3 and at 0x40 for channel 4. Channel 4 has no compare buffer, so a write to 0x40 changes nothing. All other addresses read 0.
- R4: In every cycle that a channel's manual-load bit is set, its counter and compare register load from their buffers, and counting is suppressed.
- R5: A started channel decrements by one on each cycle with its tick high. It holds without a tick. With start clear it holds its value.
- R6: A started channel whose counter is 0 expires on its next tick. With auto-reload set it then reloads counter and compare from the buffers, so a reload value N gives a period of N+1 ticks.
- R7: On an expiry without auto-reload the counter stays at 0 and the hardware clears that channel's start bit. A bus write to the control word in the same cycle takes precedence.
- R8: The interrupt register at 0x44 holds enables in bits 4:0 and pending flags in bits 9:5. An expiry sets the channel's pending flag whatever its enable. Writing 1 to a pending bit clears it. An expiry in the same cycle wins over the clear.
- R9: Interrupt line n is pending flag n AND enable n.
- R10: The compare flag of channel n (n = 0 to 3) is (counter < compare register) XOR invert. The compare flag of channel 4 is always 0.
- R11: The counter width is a parameter (16 or 32). Buffers keep only the low counter-width bits of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick | input | 5 | Per-channel count enable |
| irq | output | 5 | Per-channel interrupt lines |
| cmp_flag | output | 5 | Per-channel compare flags |

## Verification
The bench targets these corner cases:
- Period length. A design that expires on reaching zero, rather than on the tick after, would deliver N ticks per period instead of N+1.
- One-shot stop. A design that forgot to clear start would keep expiring every tick with the counter at 0.
- Irregular control layout. A wrong bit offset for channel 4's reload flag, or for the hole after channel 0, would make a channel fail to reload or would read back stray bits.
- Pending and clear collisions. The bench checks that pending flags set with the enable clear and that an expiry wins over a simultaneous write-one clear; an inverted priority would drop interrupts.
- Randomized phase. In that phase ticks, control writes and clears collide freely against a cycle-level model.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int NCH    = 5;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h08;
    localparam logic [ADDR_W-1:0] INT_ADDR  = 8'h44;
    localparam logic [ADDR_W-1:0] LAST_OBS  = 8'h40;

    typedef struct packed {
        logic start;
        logic manual;
        logic invert;
        logic autoreload;
    } ch_ctrl_t;

    // first control bit owned by channel n (a nibble is skipped after channel 0)
    function automatic int ctrl_base(input int n);
        return (n == 0) ? 0 : 4 * (n + 1);
    endfunction

    // position of the reload flag inside the channel's nibble
    function automatic int reload_off(input int n);
        return (n == NCH - 1) ? 2 : 3;
    endfunction

    function automatic logic has_cmp(input int n);
        return n < NCH - 1;
    endfunction

    function automatic logic [DATA_W-1:0] build_ctrl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int n = 0; n < NCH; n++) begin
            m[ctrl_base(n)]                 = 1'b1;
            m[ctrl_base(n) + 1]             = 1'b1;
            m[ctrl_base(n) + reload_off(n)] = 1'b1;
            if (has_cmp(n)) m[ctrl_base(n) + 2] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] CTRL_MASK = build_ctrl_mask();

    function automatic ch_ctrl_t ch_ctrl(input logic [DATA_W-1:0] w, input int n);
        ch_ctrl_t c;
        c.start      = w[ctrl_base(n)];
        c.manual     = w[ctrl_base(n) + 1];
        c.invert     = has_cmp(n) ? w[ctrl_base(n) + 2] : 1'b0;
        c.autoreload = w[ctrl_base(n) + reload_off(n)];
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] reload_buf_addr(input int n);
        return ADDR_W'(8'h0C + 12 * n);
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_buf_addr(input int n);
        return ADDR_W'(8'h10 + 12 * n);
    endfunction

    function automatic logic [ADDR_W-1:0] obs_addr(input int n);
        return (n == NCH - 1) ? LAST_OBS : ADDR_W'(8'h14 + 12 * n);
    endfunction

endpackage

// File: rtl/timer_channel.sv
module timer_channel
    import timer_pkg::*;
#(
    parameter int  CNT_W   = 16,
    parameter bit  WITH_CMP = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  ch_ctrl_t         ctl,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             expire,
    output logic             flag
);

    logic counting;

    assign counting = ctl.start && !ctl.manual && tick;
    assign expire   = counting && (count == '0);

    generate
        if (WITH_CMP) begin : g_cmp
            logic [CNT_W-1:0] cmp_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    count <= '0;
                    cmp_q <= '0;
                end else if (ctl.manual) begin
                    count <= reload_val;
                    cmp_q <= cmp_val;
                end else if (counting) begin
                    if (count != '0) begin
                        count <= count - 1'b1;
                    end else if (ctl.autoreload) begin
                        count <= reload_val;
                        cmp_q <= cmp_val;
                    end
                end
            end

            assign flag = (count < cmp_q) ^ ctl.invert;
        end else begin : g_nocmp
            always_ff @(posedge clk) begin
                if (rst) begin
                    count <= '0;
                end else if (ctl.manual) begin
                    count <= reload_val;
                end else if (counting) begin
                    if (count != '0)          count <= count - 1'b1;
                    else if (ctl.autoreload)  count <= reload_val;
                end
            end

            assign flag = 1'b0;
        end
    endgenerate

    a_r4_manual_load: assert property (@(posedge clk) disable iff (rst)
        ctl.manual |=> count == $past(reload_val));

    a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
        (ctl.start && !ctl.manual && tick && count != '0) |=> count == $past(count) - 1'b1);

    a_r5_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!ctl.start && !ctl.manual) |=> $stable(count));

    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        (expire && ctl.autoreload) |=> count == $past(reload_val));

    a_r7_stay_zero: assert property (@(posedge clk) disable iff (rst)
        (expire && !ctl.autoreload) |=> count == '0);

endmodule

// File: rtl/timer_regs.sv
module timer_regs
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic [NCH-1:0]             expire,
    output logic [DATA_W-1:0]          ctrl,
    output logic [NCH-1:0][CNT_W-1:0]  reload_buf,
    output logic [NCH-1:0][CNT_W-1:0]  cmp_buf,
    output logic [NCH-1:0]             int_en,
    output logic [NCH-1:0]             int_pend
);

    logic              ctrl_wr;
    logic              int_wr;
    logic [NCH-1:0]    clr_req;
    logic [NCH-1:0]    start_v;
    logic [NCH-1:0]    reload_v;
    logic [DATA_W-1:0] hw_clear;
    logic [DATA_W-1:0] ctrl_next;

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
    assign int_wr  = bus_wr && (bus_addr == INT_ADDR);
    assign clr_req = int_wr ? bus_wdata[2*NCH-1:NCH] : '0;

    always_comb begin
        hw_clear = '0;
        for (int n = 0; n < NCH; n++) begin
            start_v[n]  = ch_ctrl(ctrl, n).start;
            reload_v[n] = ch_ctrl(ctrl, n).autoreload;
            if (expire[n] && !reload_v[n]) hw_clear[ctrl_base(n)] = 1'b1;
        end
        // a software write to the control word wins over the one-shot stop
        ctrl_next = ctrl_wr ? (bus_wdata & CTRL_MASK) : (ctrl & ~hw_clear);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= '0;
            reload_buf <= '0;
            cmp_buf    <= '0;
            int_en     <= '0;
            int_pend   <= '0;
        end else begin
            ctrl     <= ctrl_next;
            int_pend <= (int_pend & ~clr_req) | expire;
            if (int_wr) int_en <= bus_wdata[NCH-1:0];
            for (int n = 0; n < NCH; n++) begin
                if (bus_wr && bus_addr == reload_buf_addr(n))
                    reload_buf[n] <= bus_wdata[CNT_W-1:0];
                if (has_cmp(n) && bus_wr && bus_addr == cmp_buf_addr(n))
                    cmp_buf[n] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
        ((|(expire & ~reload_v)) && !ctrl_wr) |=> ((start_v & $past(expire & ~reload_v)) == '0));

    a_r8_pend_source: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((int_pend & ~$past(int_pend) & ~$past(expire)) == '0));

    a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
        (int_wr && ((bus_wdata[2*NCH-1:NCH] & ~expire) != '0))
        |=> ((int_pend & $past(bus_wdata[2*NCH-1:NCH] & ~expire)) == '0));

endmodule

// File: rtl/timer_readmux.sv
module timer_readmux
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          ctrl,
    input  logic [NCH-1:0][CNT_W-1:0]  reload_buf,
    input  logic [NCH-1:0][CNT_W-1:0]  cmp_buf,
    input  logic [NCH-1:0][CNT_W-1:0]  counts,
    input  logic [NCH-1:0]             int_en,
    input  logic [NCH-1:0]             int_pend,
    output logic [DATA_W-1:0]          rdata
);

    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR) rdata = ctrl;
        if (addr == INT_ADDR)  rdata[2*NCH-1:0] = {int_pend, int_en};
        for (int n = 0; n < NCH; n++) begin
            if (addr == reload_buf_addr(n))            rdata[CNT_W-1:0] = reload_buf[n];
            if (has_cmp(n) && addr == cmp_buf_addr(n)) rdata[CNT_W-1:0] = cmp_buf[n];
            if (addr == obs_addr(n))                   rdata[CNT_W-1:0] = counts[n];
        end
    end

endmodule

// File: rtl/multi_timer_core.sv
module multi_timer_core
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [4:0]  tick,
    output logic [4:0]  irq,
    output logic [4:0]  cmp_flag
);

    logic [DATA_W-1:0]         ctrl;
    logic [NCH-1:0][CNT_W-1:0] reload_buf;
    logic [NCH-1:0][CNT_W-1:0] cmp_buf;
    logic [NCH-1:0][CNT_W-1:0] counts;
    logic [NCH-1:0]            expire;
    logic [NCH-1:0]            int_en;
    logic [NCH-1:0]            int_pend;

    timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .expire     (expire),
        .ctrl       (ctrl),
        .reload_buf (reload_buf),
        .cmp_buf    (cmp_buf),
        .int_en     (int_en),
        .int_pend   (int_pend)
    );

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            timer_channel #(.CNT_W(CNT_W), .WITH_CMP(has_cmp(n))) u_ch (
                .clk        (clk),
                .rst        (rst),
                .ctl        (ch_ctrl(ctrl, n)),
                .tick       (tick[n]),
                .reload_val (reload_buf[n]),
                .cmp_val    (cmp_buf[n]),
                .count      (counts[n]),
                .expire     (expire[n]),
                .flag       (cmp_flag[n])
            );
        end
    endgenerate

    timer_readmux #(.CNT_W(CNT_W)) u_rd (
        .addr       (bus_addr),
        .ctrl       (ctrl),
        .reload_buf (reload_buf),
        .cmp_buf    (cmp_buf),
        .counts     (counts),
        .int_en     (int_en),
        .int_pend   (int_pend),
        .rdata      (bus_rdata)
    );

    assign irq = int_pend & int_en;

endmodule

// File: tb/sim_multi_timer_core.sv
`timescale 1ns/1ps
module sim_multi_timer_core;

    localparam int CW = 16;
    localparam longint CMASK = (64'd1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  tick = '0;
    logic [4:0]  irq;
    logic [4:0]  cmp_flag;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    multi_timer_core #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
        .irq(irq), .cmp_flag(cmp_flag)
    );

    // ---------------- behavioural reference model ----------------
    longint    m_cnt[5], m_cmp[5], m_rl[5], m_cb[5];
    bit [31:0] m_ctrl;
    bit [4:0]  m_en, m_pend;

    function automatic int nib(int c);
        return (c == 0) ? 0 : 4 * (c + 1);
    endfunction

    function automatic bit [31:0] m_read(bit [7:0] a);
        bit [31:0] r;
        r = 0;
        if (a == 8'h08) r = m_ctrl;
        if (a == 8'h44) r = {22'd0, m_pend, m_en};
        for (int c = 0; c < 5; c++) begin
            if (a == 8'(12 * c + 'h0C)) r = 32'(m_rl[c]);
            if (c < 4 && a == 8'(12 * c + 'h10)) r = 32'(m_cb[c]);
            if (c < 4 && a == 8'(12 * c + 'h14)) r = 32'(m_cnt[c]);
        end
        if (a == 8'h40) r = 32'(m_cnt[4]);
        return r;
    endfunction

    function automatic bit [4:0] m_flags();
        bit [4:0] f;
        f = 0;
        for (int c = 0; c < 4; c++) f[c] = (m_cnt[c] < m_cmp[c]) ^ m_ctrl[nib(c) + 2];
        return f;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 5; c++) begin
                m_cnt[c] = 0; m_cmp[c] = 0; m_rl[c] = 0; m_cb[c] = 0;
            end
            m_ctrl = 0; m_en = 0; m_pend = 0;
        end else begin
            bit [31:0] oc;
            longint    orl[5], ocb[5];
            bit [4:0]  ex, clr;
            oc = m_ctrl; ex = 0; clr = 0;
            for (int c = 0; c < 5; c++) begin orl[c] = m_rl[c]; ocb[c] = m_cb[c]; end
            for (int c = 0; c < 5; c++) begin
                bit st, mu, ar;
                st = oc[nib(c)]; mu = oc[nib(c) + 1];
                ar = (c == 4) ? oc[nib(c) + 2] : oc[nib(c) + 3];
                if (mu) begin
                    m_cnt[c] = orl[c]; m_cmp[c] = ocb[c];
                end else if (st && tick[c]) begin
                    if (m_cnt[c] == 0) begin
                        ex[c] = 1;
                        if (ar) begin m_cnt[c] = orl[c]; m_cmp[c] = ocb[c]; end
                        else m_ctrl[nib(c)] = 0;
                    end else m_cnt[c] = m_cnt[c] - 1;
                end
            end
            if (bus_wr) begin
                if (bus_addr == 8'h08) m_ctrl = bus_wdata & 32'h007F_FF0F;
                if (bus_addr == 8'h44) begin m_en = bus_wdata[4:0]; clr = bus_wdata[9:5]; end
                for (int c = 0; c < 5; c++) begin
                    if (bus_addr == 8'(12 * c + 'h0C)) m_rl[c] = bus_wdata & CMASK;
                    if (c < 4 && bus_addr == 8'(12 * c + 'h10)) m_cb[c] = bus_wdata & CMASK;
                end
            end
            m_pend = (m_pend & ~clr) | ex;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model, just after the edge
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            chk(irq == (m_pend & m_en), "R9 irq vs model", irq, m_pend & m_en);
            chk(cmp_flag == m_flags(), "R10 cmp_flag vs model", cmp_flag, m_flags());
            chk(bus_rdata == m_read(bus_addr), "R3 rdata vs model", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_chk(input bit [7:0] a, input bit [31:0] exp, input string req);
        bus_addr = a;
        #1;
        chk(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int n;
        bit [31:0] v1;
        idle(3);
        rst = 0;
        idle(1);
        // R1 reset state
        rd_chk(8'h08, 0, "R1 ctrl after reset");
        rd_chk(8'h44, 0, "R1 int reg after reset");
        rd_chk(8'h14, 0, "R1 observation after reset");
        chk(irq == 0, "R1 irq after reset", irq, 0);
        chk(cmp_flag == 0, "R1 cmp_flag after reset", cmp_flag, 0);

        // R2 control layout
        wr(8'h08, 32'hFFFF_FFFF);
        rd_chk(8'h08, 32'h007F_FF0F, "R2 ctrl writable bits");
        wr(8'h08, 0);

        // R11 buffer width, R3 map
        wr(8'h24, 32'h0001_2345);
        rd_chk(8'h24, 32'h0000_2345, "R11 buffer truncated");
        wr(8'h3C, 1);
        wr(8'h40, 32'h0000_0077);
        rd_chk(8'h3C, 1, "R3 write to 0x40 ignored");
        rd_chk(8'h40, 0, "R3 channel 4 observation");
        rd_chk(8'h48, 0, "R3 unmapped reads zero");

        // R6 periodic channel 0, period N+1
        tick = 5'b00001;
        wr(8'h0C, 3);
        wr(8'h10, 1);
        wr(8'h44, 32'h1);
        wr(8'h08, 32'h2);
        rd_chk(8'h14, 0, "R4 manual not yet applied");
        wr(8'h08, 32'h9);
        rd_chk(8'h14, 3, "R4 manual load of counter");
        n = 0;
        while (!irq[0] && n < 20) begin @(negedge clk); n++; end
        chk(n == 4, "R6 period is N+1 ticks", n, 4);
        rd_chk(8'h14, 3, "R6 reload after expiry");
        wr(8'h08, 0);
        wr(8'h44, 32'h3E0);
        rd_chk(8'h44, 0, "R8 W1C clears all");

        // R7 one-shot channel 1, R8 pending without enable
        tick = 5'b00010;
        wr(8'h18, 2);
        wr(8'h08, 32'h200);
        wr(8'h08, 32'h100);
        idle(6);
        rd_chk(8'h08, 0, "R7 start cleared by one-shot");
        rd_chk(8'h20, 0, "R7 counter stays at zero");
        rd_chk(8'h44, 32'h40, "R8 pending set while disabled");
        chk(irq == 0, "R9 no irq while disabled", irq, 0);
        wr(8'h44, 32'h02);
        chk(irq == 5'b00010, "R9 irq when enabled", irq, 5'b00010);
        wr(8'h44, 32'h42);
        rd_chk(8'h44, 32'h02, "R8 write one clears pending");

        // R5 freeze and tick gating, channel 2
        tick = 5'b00100;
        wr(8'h24, 100);
        wr(8'h08, 32'h2000);
        wr(8'h08, 32'h1000);
        idle(10);
        wr(8'h08, 0);
        bus_addr = 8'h2C; #1; v1 = bus_rdata;
        chk(v1 < 100 && v1 > 80, "R5 counted down", v1, 90);
        idle(5);
        rd_chk(8'h2C, v1, "R5 frozen with start clear");
        tick = 0;
        wr(8'h08, 32'h1000);
        bus_addr = 8'h2C; #1; v1 = bus_rdata;
        idle(5);
        rd_chk(8'h2C, v1, "R5 no change without tick");
        wr(8'h08, 0);

        // R10 compare flag and invert, channel 3
        wr(8'h30, 10);
        wr(8'h34, 5);
        wr(8'h08, 32'h2_0000);
        wr(8'h08, 0);
        chk(cmp_flag[3] == 0, "R10 count above compare", cmp_flag[3], 0);
        wr(8'h08, 32'h4_0000);
        chk(cmp_flag[3] == 1, "R10 invert", cmp_flag[3], 1);
        tick = 5'b01000;
        wr(8'h08, 32'h5_0000);
        idle(15);
        rd_chk(8'h38, 0, "R7 channel 3 stopped at zero");
        chk(cmp_flag[3] == 0, "R10 zero below compare inverted", cmp_flag[3], 0);

        // channel 4: moved reload bit, observation at 0x40
        wr(8'h44, 32'h3F0);
        tick = 5'b10000;
        wr(8'h08, 32'h20_0000);
        wr(8'h08, 32'h50_0000);
        n = 0;
        while (!irq[4] && n < 20) begin @(negedge clk); n++; end
        chk(n == 2, "R6 channel 4 period with reload at bit 22", n, 2);
        chk(cmp_flag[4] == 0, "R10 channel 4 has no flag", cmp_flag[4], 0);
        rd_chk(8'h08, 32'h50_0000, "R2 channel 4 keeps running");
        wr(8'h08, 0);
        wr(8'h44, 32'h3E0);

        // randomized phase, model compared every clock
        for (int c = 0; c < 5; c++) begin
            wr(8'(12 * c + 'h0C), $urandom_range(9, 0));
            if (c < 4) wr(8'(12 * c + 'h10), $urandom_range(9, 0));
        end
        wr(8'h44, 32'h1F);
        wr(8'h08, 32'h007F_BB0A);
        wr(8'h08, 32'h0059_9909);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            tick = 5'($urandom);
            bus_addr = 8'($urandom_range(18, 0) * 4);
            bus_wr = 0;
            if ($urandom_range(15, 0) == 0) begin
                bus_wr = 1; bus_addr = 8'h44; bus_wdata = {22'd0, 5'($urandom), 5'h1F};
            end else if ($urandom_range(63, 0) == 0) begin
                bus_wr = 1; bus_addr = 8'h08; bus_wdata = $urandom;
            end else if ($urandom_range(63, 0) == 0) begin
                bus_wr = 1; bus_wdata = $urandom_range(12, 0);
            end
        end
        @(negedge clk);
        bus_wr = 0;
        idle(2);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule